// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and presents them to a processor as two interrupt outputs: a normal one and a fast one. Every source has an enable bit, a route bit that steers it to the fast or the normal output, a software force bit and a 4-bit priority. Among the enabled normal sources that are requesting, the block picks the one with the highest priority and reports its number and priority in a vector word. The normal output is raised only when that priority lies above a programmable 5-bit threshold.

Software programs the block through a 32-bit register port with a single write strobe and a combinational read path. Per-source bitmaps are split into an upper word for sources 32 to 63 and a lower word for sources 0 to 31. Enables may be changed as whole words or one at a time by writing a source number. Because requests are level-sensitive, a handler acknowledges a source by clearing its enable and turns it back on once the device has dropped its request.

This block has no state machine. Its only stored state is the register set, and the arbiter is purely combinational.

Top module: `vpic_top`

## Requirements
- R1: After reset, every enable, route, force and priority bit is 0, the control word is 0, the threshold reads 0x1F, both interrupt outputs are low, and both vector words read 0xFFFFFFFF.
- R2: Writing to byte address 0x08 sets the enable of the source numbered by write-data bits [5:0] and leaves all other enables unchanged. Reading 0x08 returns 0.
- R3: Writing to byte address 0x0C clears the enable of the source numbered by write-data bits [5:0] and leaves all other enables unchanged. Reading 0x0C returns 0.
- R4: Enables (0x10 upper, 0x14 lower), route bits (0x18 upper, 0x1C lower) and force bits (0x50 upper, 0x54 lower) can be written and read back as whole words. Bit k of an upper word belongs to source 32+k, and bit k of a lower word belongs to source k. A route bit of 1 means fast and 0 means normal.
- R5: The priority of source n occupies bits [4*(n%8)+3 : 4*(n%8)] of the word at byte address 0x20 + 4*(7 - n/8). That word is readable and writable, so sources 56 to 63 sit at 0x20 and sources 0 to 7 sit at 0x3C.
- R6: The request words (0x48 upper, 0x4C lower) read request input OR force bit. Normal pending (0x58/0x5C) reads request & enable & ~route. Fast pending (0x60/0x64) reads request & enable & route.
- R7: The threshold register at 0x04 holds bits [4:0]. irq_normal is high exactly when the winning normal source's priority, zero-extended to 5 bits, is strictly greater than the threshold.
- R8: irq_fast is high exactly when at least one fast-pending bit is set.
- R9: The normal vector word at 0x40 reads {source number in [31:16], priority in [15:0]} of the normal-pending source with the highest priority. Ties go to the highest source number. It reads 0xFFFFFFFF when nothing is normal-pending, whatever the threshold.
- R10: The fast vector word at 0x44 reads the highest-numbered fast-pending source in [31:16] and zero in [15:0]. It reads 0xFFFFFFFF when nothing is fast-pending.
- R11: The control word at 0x00 reads back what was written. Writes to read-only words (0x40 to 0x4C, 0x58 to 0x64), to unmapped addresses, or to addresses whose bits [1:0] are not 0 change nothing. Such unmapped or misaligned reads return 0.
- R12: Requests are level-sensitive. Clearing a source's enable, or dropping both its request input and its force bit, removes it from pending, from the vectors and from the outputs in the same cycle the change becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 7 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_req | input | 64 | Level-sensitive request lines, one per source |
| irq_normal | output | 1 | Normal interrupt request to the processor |
| irq_fast | output | 1 | Fast interrupt request to the processor |

## Verification
The directed part places equal priorities on the lowest and the highest source to show which way ties break. It sets the threshold equal to, and then one below, the winning priority to pin down the strict comparison, and it moves a source from normal to fast to show the route bit splitting the two vectors. Random rounds mix whole-word writes, by-number enable and disable writes, misaligned and read-only writes, force bits and changing request lines. The threshold is kept mostly low so the normal output toggles often. After each step every register and both outputs are compared against a bench model, which separates errors in decoding, bit placement, pending logic and arbitration order.

// File: rtl/vpic_pkg.sv
`timescale 1ns/1ps
package vpic_pkg;
    localparam int SRC_N      = 64;
    localparam int DATA_W     = 32;
    localparam int HALF_W     = DATA_W / 2;
    localparam int PRIO_W     = 4;
    localparam int THR_W      = PRIO_W + 1;
    localparam int ADDR_W     = 7;
    localparam int IDX_W      = $clog2(SRC_N);
    localparam int PRI_PER_W  = DATA_W / PRIO_W;
    localparam int PRI_WORDS  = SRC_N / PRI_PER_W;
    localparam int PRI_SEL_W  = $clog2(PRI_WORDS);

    localparam logic [ADDR_W-1:0] A_CTL   = 7'h00;
    localparam logic [ADDR_W-1:0] A_THR   = 7'h04;
    localparam logic [ADDR_W-1:0] A_SETN  = 7'h08;
    localparam logic [ADDR_W-1:0] A_CLRN  = 7'h0C;
    localparam logic [ADDR_W-1:0] A_ENH   = 7'h10;
    localparam logic [ADDR_W-1:0] A_ENL   = 7'h14;
    localparam logic [ADDR_W-1:0] A_RTH   = 7'h18;
    localparam logic [ADDR_W-1:0] A_RTL   = 7'h1C;
    localparam logic [ADDR_W-1:0] A_NVEC  = 7'h40;
    localparam logic [ADDR_W-1:0] A_FVEC  = 7'h44;
    localparam logic [ADDR_W-1:0] A_REQH  = 7'h48;
    localparam logic [ADDR_W-1:0] A_REQL  = 7'h4C;
    localparam logic [ADDR_W-1:0] A_FRH   = 7'h50;
    localparam logic [ADDR_W-1:0] A_FRL   = 7'h54;
    localparam logic [ADDR_W-1:0] A_NPH   = 7'h58;
    localparam logic [ADDR_W-1:0] A_NPL   = 7'h5C;
    localparam logic [ADDR_W-1:0] A_FPH   = 7'h60;
    localparam logic [ADDR_W-1:0] A_FPL   = 7'h64;

    // priority words live in 0x20..0x3C: bits [6:5] == 2'b01, aligned
    function automatic logic is_pri_addr(logic [ADDR_W-1:0] a);
        return (a[6:5] == 2'b01) && (a[1:0] == 2'b00);
    endfunction

    // reverse placement: lowest address holds the highest source group
    function automatic logic [PRI_SEL_W-1:0] pri_group(logic [ADDR_W-1:0] a);
        return PRI_SEL_W'(PRI_WORDS - 1) - a[PRI_SEL_W+1:2];
    endfunction
endpackage

// File: rtl/vpic_regs.sv
`timescale 1ns/1ps
module vpic_regs
    import vpic_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        ctl_q,
    output logic [THR_W-1:0]         thr_q,
    output logic [SRC_N-1:0]         en_q,
    output logic [SRC_N-1:0]         route_q,
    output logic [SRC_N-1:0]         force_q,
    output logic [SRC_N*PRIO_W-1:0]  pri_q
);
    localparam logic [SRC_N-1:0] ONE = {{(SRC_N-1){1'b0}}, 1'b1};

    logic [IDX_W-1:0] num;
    assign num = wdata[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            thr_q   <= '1;
            en_q    <= '0;
            route_q <= '0;
            force_q <= '0;
            pri_q   <= '0;
        end else if (wr) begin
            case (addr)
                A_CTL:  ctl_q <= wdata;
                A_THR:  thr_q <= wdata[THR_W-1:0];
                A_SETN: en_q  <= en_q | (ONE << num);
                A_CLRN: en_q  <= en_q & ~(ONE << num);
                A_ENH:  en_q[DATA_W +: DATA_W]    <= wdata;
                A_ENL:  en_q[0 +: DATA_W]         <= wdata;
                A_RTH:  route_q[DATA_W +: DATA_W] <= wdata;
                A_RTL:  route_q[0 +: DATA_W]      <= wdata;
                A_FRH:  force_q[DATA_W +: DATA_W] <= wdata;
                A_FRL:  force_q[0 +: DATA_W]      <= wdata;
                default: begin
                    if (is_pri_addr(addr))
                        pri_q[pri_group(addr)*DATA_W +: DATA_W] <= wdata;
                end
            endcase
        end
    end

    assert_setnum_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_SETN) |=> (en_q == ($past(en_q) | (ONE << $past(num)))));

    assert_clrnum_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CLRN) |=> (en_q == ($past(en_q) & ~(ONE << $past(num)))));

    assert_ro_write_keeps_enables_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_NVEC) |=> $stable(en_q));
endmodule

// File: rtl/vpic_arb.sv
`timescale 1ns/1ps
module vpic_arb
    import vpic_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SRC_N-1:0]         pend_n,
    input  logic [SRC_N-1:0]         pend_f,
    input  logic [SRC_N*PRIO_W-1:0]  pri,
    output logic                     n_valid,
    output logic [IDX_W-1:0]         n_idx,
    output logic [PRIO_W-1:0]        n_prio,
    output logic                     f_valid,
    output logic [IDX_W-1:0]         f_idx
);
    // normal: scan upward, ">=" hands ties to the higher number
    always_comb begin
        n_valid = 1'b0;
        n_idx   = '0;
        n_prio  = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (pend_n[i] && (!n_valid || pri[i*PRIO_W +: PRIO_W] >= n_prio)) begin
                n_valid = 1'b1;
                n_idx   = IDX_W'(i);
                n_prio  = pri[i*PRIO_W +: PRIO_W];
            end
        end
    end

    // fast: highest-numbered pending source
    always_comb begin
        f_valid = 1'b0;
        f_idx   = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (pend_f[i]) begin
                f_valid = 1'b1;
                f_idx   = IDX_W'(i);
            end
        end
    end

    assert_winner_is_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        n_valid |-> pend_n[n_idx]);

    assert_fast_winner_is_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        f_valid |-> pend_f[f_idx]);
endmodule

// File: rtl/vpic_top.sv
`timescale 1ns/1ps
module vpic_top
    import vpic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [SRC_N-1:0]     src_req,
    output logic                 irq_normal,
    output logic                 irq_fast
);
    logic [DATA_W-1:0]       ctl_q;
    logic [THR_W-1:0]        thr_q;
    logic [SRC_N-1:0]        en_q, route_q, force_q;
    logic [SRC_N*PRIO_W-1:0] pri_q;
    logic [SRC_N-1:0]        raw, pend_n, pend_f;
    logic                    n_valid, f_valid;
    logic [IDX_W-1:0]        n_idx, f_idx;
    logic [PRIO_W-1:0]       n_prio;
    logic [DATA_W-1:0]       nvec, fvec;

    vpic_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .ctl_q(ctl_q), .thr_q(thr_q), .en_q(en_q), .route_q(route_q),
        .force_q(force_q), .pri_q(pri_q)
    );

    assign raw    = src_req | force_q;
    assign pend_n = raw & en_q & ~route_q;
    assign pend_f = raw & en_q & route_q;

    vpic_arb u_arb (
        .clk(clk), .rst_n(rst_n), .pend_n(pend_n), .pend_f(pend_f), .pri(pri_q),
        .n_valid(n_valid), .n_idx(n_idx), .n_prio(n_prio),
        .f_valid(f_valid), .f_idx(f_idx)
    );

    assign irq_normal = n_valid && ({1'b0, n_prio} > thr_q);
    assign irq_fast   = |pend_f;

    assign nvec = n_valid ? {HALF_W'(n_idx), HALF_W'(n_prio)} : '1;
    assign fvec = f_valid ? {HALF_W'(f_idx), HALF_W'(0)}      : '1;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTL:  reg_rdata = ctl_q;
            A_THR:  reg_rdata = DATA_W'(thr_q);
            A_ENH:  reg_rdata = en_q[DATA_W +: DATA_W];
            A_ENL:  reg_rdata = en_q[0 +: DATA_W];
            A_RTH:  reg_rdata = route_q[DATA_W +: DATA_W];
            A_RTL:  reg_rdata = route_q[0 +: DATA_W];
            A_NVEC: reg_rdata = nvec;
            A_FVEC: reg_rdata = fvec;
            A_REQH: reg_rdata = raw[DATA_W +: DATA_W];
            A_REQL: reg_rdata = raw[0 +: DATA_W];
            A_FRH:  reg_rdata = force_q[DATA_W +: DATA_W];
            A_FRL:  reg_rdata = force_q[0 +: DATA_W];
            A_NPH:  reg_rdata = pend_n[DATA_W +: DATA_W];
            A_NPL:  reg_rdata = pend_n[0 +: DATA_W];
            A_FPH:  reg_rdata = pend_f[DATA_W +: DATA_W];
            A_FPL:  reg_rdata = pend_f[0 +: DATA_W];
            default: begin
                if (is_pri_addr(reg_addr))
                    reg_rdata = pri_q[pri_group(reg_addr)*DATA_W +: DATA_W];
            end
        endcase
    end

    assert_normal_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_normal |-> (pend_n != '0));

    assert_full_threshold_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q == '1) |-> !irq_normal);

    assert_fast_matches_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast == f_valid);
endmodule

// File: tb/vpic_top_tb.sv
`timescale 1ns/1ps
module vpic_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] src_req = '0;
    logic        irq_normal, irq_fast;

    int total = 0;
    int bad = 0;

    logic [63:0] m_en = '0, m_rt = '0, m_fr = '0;
    logic [3:0]  m_pri [64];
    logic [4:0]  m_thr = 5'h1F;
    logic [31:0] m_ctl = '0;

    always #5 clk = ~clk;

    vpic_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .irq_normal(irq_normal), .irq_fast(irq_fast)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] m_raw();
        return src_req | m_fr;
    endfunction

    function automatic logic [31:0] exp_nvec();
        logic [63:0] np;
        logic found;
        logic [3:0] best;
        int idx;
        np = m_raw() & m_en & ~m_rt;
        found = 1'b0; best = '0; idx = 0;
        for (int i = 0; i < 64; i++)
            if (np[i] && (!found || m_pri[i] >= best)) begin
                found = 1'b1; best = m_pri[i]; idx = i;
            end
        return found ? {16'(idx), 12'h0, best} : 32'hFFFF_FFFF;
    endfunction

    function automatic logic exp_irqn();
        logic [31:0] v;
        v = exp_nvec();
        return (v != 32'hFFFF_FFFF) && ({1'b0, v[3:0]} > m_thr);
    endfunction

    function automatic logic [31:0] exp_fvec();
        logic [63:0] fp;
        logic [31:0] r;
        fp = m_raw() & m_en & m_rt;
        r = 32'hFFFF_FFFF;
        for (int i = 0; i < 64; i++)
            if (fp[i]) r = {16'(i), 16'h0};
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(logic [6:0] a);
        logic [63:0] raw;
        logic [31:0] w;
        int g;
        raw = m_raw();
        case (a)
            7'h00: return m_ctl;
            7'h04: return 32'(m_thr);
            7'h10: return m_en[63:32];
            7'h14: return m_en[31:0];
            7'h18: return m_rt[63:32];
            7'h1C: return m_rt[31:0];
            7'h40: return exp_nvec();
            7'h44: return exp_fvec();
            7'h48: return raw[63:32];
            7'h4C: return raw[31:0];
            7'h50: return m_fr[63:32];
            7'h54: return m_fr[31:0];
            7'h58: return (raw & m_en & ~m_rt) >> 32;
            7'h5C: return 32'(raw & m_en & ~m_rt);
            7'h60: return (raw & m_en & m_rt) >> 32;
            7'h64: return 32'(raw & m_en & m_rt);
            default: begin
                if (a >= 7'h20 && a <= 7'h3C && a[1:0] == 2'b00) begin
                    g = 7 - ((int'(a) - 32) / 4);
                    w = '0;
                    for (int k = 0; k < 8; k++) w[4*k +: 4] = m_pri[8*g + k];
                    return w;
                end
                return 32'h0;
            end
        endcase
    endfunction

    function automatic string req_of(logic [6:0] a);
        if (a == 7'h04) return "R7";
        if (a == 7'h08) return "R2";
        if (a == 7'h0C) return "R3";
        if (a >= 7'h10 && a <= 7'h1C) return "R4";
        if (a >= 7'h20 && a <= 7'h3C) return "R5";
        if (a == 7'h40) return "R9";
        if (a == 7'h44) return "R10";
        if (a == 7'h50 || a == 7'h54) return "R4";
        if (a >= 7'h48 && a <= 7'h64) return "R6";
        return "R11";
    endfunction

    task automatic model_wr(logic [6:0] a, logic [31:0] d);
        int g;
        case (a)
            7'h00: m_ctl = d;
            7'h04: m_thr = d[4:0];
            7'h08: m_en[d[5:0]] = 1'b1;
            7'h0C: m_en[d[5:0]] = 1'b0;
            7'h10: m_en[63:32] = d;
            7'h14: m_en[31:0] = d;
            7'h18: m_rt[63:32] = d;
            7'h1C: m_rt[31:0] = d;
            7'h50: m_fr[63:32] = d;
            7'h54: m_fr[31:0] = d;
            default: begin
                if (a >= 7'h20 && a <= 7'h3C && a[1:0] == 2'b00) begin
                    g = 7 - ((int'(a) - 32) / 4);
                    for (int k = 0; k < 8; k++) m_pri[8*g + k] = d[4*k +: 4];
                end
            end
        endcase
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd(logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_outs(string tag);
        @(negedge clk);
        #1;
        chk({tag, " R7"}, "irq_normal", 32'(irq_normal), 32'(exp_irqn()));
        chk({tag, " R8"}, "irq_fast", 32'(irq_fast), 32'(|(m_raw() & m_en & m_rt)));
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        for (int a = 0; a <= 'h68; a += 4) begin
            rd(7'(a), d);
            chk({tag, " ", req_of(7'(a))}, $sformatf("rd %02h", a), d, exp_rd(7'(a)));
        end
        rd(7'h41, d);
        chk({tag, " R11"}, "misaligned rd", d, 32'h0);
        check_outs(tag);
    endtask

    task automatic expect_rd(string req, logic [6:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, $sformatf("rd %02h", a), d, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [6:0] a;
        logic [31:0] d;
        logic [6:0] waddr [18] = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h10, 7'h14, 7'h18,
                                  7'h1C, 7'h20, 7'h2C, 7'h3C, 7'h50, 7'h54, 7'h40,
                                  7'h5C, 7'h09, 7'h68, 7'h34};
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) m_pri[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        check_all("R1");
        expect_rd("R1", 7'h04, 32'h1F);
        expect_rd("R1", 7'h40, 32'hFFFF_FFFF);

        // R2 set by number, only bits [5:0] used
        wr(7'h08, 32'd5);
        wr(7'h08, 32'd40);
        wr(7'h08, 32'hFFFF_FFC3);
        expect_rd("R2", 7'h14, 32'h0000_0028);
        expect_rd("R2", 7'h10, 32'h0000_0100);
        expect_rd("R2", 7'h08, 32'h0);
        // R3 clear by number
        wr(7'h0C, 32'd5);
        expect_rd("R3", 7'h14, 32'h0000_0008);
        expect_rd("R3", 7'h0C, 32'h0);
        // R5 reversed priority placement
        wr(7'h3C, 32'h0000_00A0);
        wr(7'h20, 32'hA000_0000);
        check_all("R5");
        // R9 tie between source 1 and 63, R7 threshold boundary
        src_req = 64'h8000_0000_0000_0002;
        wr(7'h08, 32'd1);
        wr(7'h08, 32'd63);
        expect_rd("R9", 7'h40, 32'h003F_000A);
        check_outs("R7 full threshold");
        wr(7'h04, 32'h0A);
        check_outs("R7 equal");
        wr(7'h04, 32'h09);
        check_outs("R7 one below");
        // R8 R10 route source 63 to fast
        wr(7'h18, 32'h8000_0000);
        expect_rd("R10", 7'h44, 32'h003F_0000);
        expect_rd("R9", 7'h40, 32'h0001_000A);
        check_outs("R8");
        // R11 read-only and misaligned writes, control read back
        wr(7'h40, 32'h0);
        wr(7'h5C, 32'h0);
        wr(7'h15, 32'h0);
        wr(7'h00, 32'h1234_5678);
        check_all("R11");
        // R12 acknowledge by disable, then force as source
        wr(7'h0C, 32'd1);
        expect_rd("R12", 7'h40, 32'hFFFF_FFFF);
        check_outs("R12");
        wr(7'h54, 32'h4);
        wr(7'h08, 32'd2);
        expect_rd("R12", 7'h5C, 32'h4);
        wr(7'h54, 32'h0);
        expect_rd("R12", 7'h5C, 32'h0);
        src_req = '0;
        expect_rd("R12", 7'h44, 32'hFFFF_FFFF);
        check_all("R12");

        // random rounds
        for (int it = 0; it < 250; it++) begin
            a = waddr[$urandom % 18];
            d = {$urandom, $urandom} [31:0];
            if (a == 7'h04) d = 32'($urandom % 20);
            if (a == 7'h08 || a == 7'h0C) d = 32'($urandom % 64);
            if ($urandom % 3 == 0) src_req = {$urandom, $urandom} & {$urandom, $urandom};
            wr(a, d);
            check_all("rand");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule